// File: doc/BRIEF.md
# Radix-2^k Montgomery Modular Multiplier

The block computes the Montgomery product `a·b·2^(-K·N) mod m` for an odd modulus `m`. The multiplier `a` is taken as `N` digits of `K` bits and consumed one digit per clock cycle, least significant digit first. Each step adds the digit's multiple of `b` to an accumulator. It then adds a quotient multiple of `m` that clears the accumulator's low `K` bits, and shifts the sum right by `K`. After `N` steps a single conditional subtraction brings the value into `[0, m)`.

The caller supplies `mprime_i`, the inverse of `-m` modulo `2^K`. It is the only precomputed constant the datapath uses, and no inverse of `2^K` is ever formed. Operands are latched on an accepted start pulse. The result appears with a one-cycle done pulse and is held until the next completion. Domain conversion constants and exponentiation sequencing belong to the surrounding logic.

Top module: `mont_mul`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it, `busy_o`, `done_o` and `res_o` are all zero.
- R2: A `start_i` sampled while idle sets `busy_o` on the next cycle. `done_o` rises exactly `N+2` clock edges after the edge that sampled the start, where the sampling edge is counted as the first (18 with the defaults).
- R3: With `m` odd, `b < m` and `mprime_i == (-m)^-1 mod 2^K`, the result equals `a·b·2^(-K·N) mod m`.
- R4: Every delivered result is strictly less than `m`, including when the last accumulator lies in `[m, 2m)`.
- R5: A `start_i` pulse while `busy_o` is high is ignored. Operand inputs changed during a run do not affect its result.
- R6: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. A `start_i` given in that same cycle is accepted.
- R7: `res_o` keeps its value from one `done_o` pulse to the next.
- R8: A zero multiplier or a zero multiplicand gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| a_i | input | K·N | Multiplier, consumed low digit first |
| b_i | input | MW | Multiplicand, must be below m |
| m_i | input | MW | Odd modulus |
| mprime_i | input | K | Inverse of -m modulo 2^K |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle pulse when res_o is valid |
| res_o | output | MW | Reduced Montgomery product |

## Verification
Two events can land in the same cycle: completion (the done pulse with the final subtraction) and acceptance of the next start. The bench raises `start_i` in the cycle where `done_o` is seen. It then checks three things: the first result is intact, `busy_o` rises on the next cycle, and the second product is correct. The bench also pulses start mid-run with different operands, and checks that the first result is unchanged against an independent reference. That reference is built from a full-width product followed by repeated halving modulo `m`.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mont_state_e;
endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  mont_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic last;

  assign last   = (cnt_q == CW'(N - 1));
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (last)    state_d = ST_FIN;
      ST_FIN:               state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  busy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R2
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && last) |=> fin_o);
endmodule

// File: rtl/mont_digit_step.sv
module mont_digit_step #(
  parameter int MW = 64,
  parameter int K  = 4
) (
  input  logic [MW:0]   acc_i,
  input  logic [K-1:0]  digit_i,
  input  logic [MW-1:0] b_i,
  input  logic [MW-1:0] m_i,
  input  logic [K-1:0]  mprime_i,
  output logic [MW:0]   acc_o,
  output logic [K-1:0]  low_o
);
  // acc < 2m, b < m: sum < 2^(K+1)·m, fits MW+K+1 bits
  localparam int SW = MW + K + 1;

  logic [SW-1:0] part, full;
  logic [K-1:0]  q;

  always_comb begin
    part  = SW'(acc_i) + SW'(digit_i) * SW'(b_i);
    q     = part[K-1:0] * mprime_i;
    full  = part + SW'(q) * SW'(m_i);
    acc_o = full[SW-1:K];
    low_o = full[K-1:0];
  end
endmodule

// File: rtl/mont_final_sub.sv
module mont_final_sub #(
  parameter int MW = 64
) (
  input  logic [MW:0]   acc_i,
  input  logic [MW-1:0] m_i,
  output logic [MW-1:0] res_o
);
  logic          ge;
  logic [MW-1:0] diff;

  always_comb begin
    ge    = (acc_i >= {1'b0, m_i});
    diff  = acc_i[MW-1:0] - m_i;
    res_o = ge ? diff : acc_i[MW-1:0];
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int MW = 64,
  parameter int K  = 4,
  parameter int N  = (MW + K - 1) / K,
  localparam int AW = K * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_i,
  input  logic [MW-1:0] b_i,
  input  logic [MW-1:0] m_i,
  input  logic [K-1:0]  mprime_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [MW-1:0] res_o
);
  logic load, step, fin;
  logic [AW-1:0] a_q;
  logic [MW-1:0] b_q, m_q, res_q, res_sub;
  logic [K-1:0]  mp_q, low;
  logic [MW:0]   acc_q, acc_nxt;
  logic          done_q;

  mont_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o)
  );

  mont_digit_step #(.MW(MW), .K(K)) u_step (
    .acc_i   (acc_q),
    .digit_i (a_q[K-1:0]),
    .b_i     (b_q),
    .m_i     (m_q),
    .mprime_i(mp_q),
    .acc_o   (acc_nxt),
    .low_o   (low)
  );

  mont_final_sub #(.MW(MW)) u_sub (
    .acc_i(acc_q),
    .m_i  (m_q),
    .res_o(res_sub)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      m_q   <= '0;
      mp_q  <= '0;
      acc_q <= '0;
    end else if (load) begin
      a_q   <= a_i;
      b_q   <= b_i;
      m_q   <= m_i;
      mp_q  <= mprime_i;
      acc_q <= '0;
    end else if (step) begin
      a_q   <= a_q >> K;
      acc_q <= acc_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) res_q <= res_sub;
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;

  // R3
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (low == '0));

  // R3
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> ({1'b0, acc_q} < {m_q, 1'b0}));

  // R4
  res_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (res_q < m_q));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);

  // R5
  hold_opnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(m_q) && $stable(b_q) && $stable(mp_q)));

  // R7
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> $stable(res_q));
endmodule

// File: tb/sim_mont_mul.sv
module sim_mont_mul;
  localparam int MW = 64;
  localparam int K  = 4;
  localparam int N  = MW / K;
  localparam int NV = 6;

  // a, b, m
  localparam logic [63:0] VEC [NV][3] = '{
    '{64'h0123_4567_89AB_CDEF, 64'h0FED_CBA9_8765_4321, 64'hF000_0000_0000_0001},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF},
    '{64'h1,                   64'h1,                   64'h3},
    '{64'h0,                   64'h1234,                64'h1_0001},
    '{64'hDEAD_BEEF,           64'h0,                   64'h9},
    '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] a = '0, b = '0, m = '0;
  logic [K-1:0] mp = '0;
  logic busy, done;
  logic [63:0] res;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mont_mul #(.MW(MW), .K(K)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .m_i(m), .mprime_i(mp), .busy_o(busy), .done_o(done), .res_o(res)
  );

  function automatic logic [63:0] ref_mont(input logic [63:0] x, y, md);
    logic [127:0] p;
    logic [65:0]  v;
    p = ({64'd0, x} * {64'd0, y}) % {64'd0, md};
    v = p[65:0];
    for (int i = 0; i < K * N; i++)
      v = v[0] ? (v + {2'b0, md}) >> 1 : v >> 1;
    return v[63:0];
  endfunction

  function automatic logic [K-1:0] inv_neg(input logic [63:0] md);
    logic [K-1:0] r = '0;
    for (int t = 0; t < (1 << K); t++)
      if (((md[K-1:0] * K'(t)) + K'(1)) == '0) r = K'(t);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [63:0] xa, xb, xm);
    a = xa; b = xb; m = xm; mp = inv_neg(xm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int edges);
    edges = 1;
    while (!done && edges < 200) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic run_one(input logic [63:0] xa, xb, xm, input string tag);
    int e;
    logic [63:0] exp_v, held;
    exp_v = ref_mont(xa, xb, xm);
    kick(xa, xb, xm);
    chk(busy == 1'b1, "R2 busy", 64'(busy), 64'd1);
    wait_done(e);
    chk(e == N + 2, "R2 latency", 64'(e), 64'(N + 2));
    chk(res == exp_v, tag, res, exp_v);
    chk(res < xm, "R4 range", res, xm);
    chk(busy == 1'b0, "R6 idle at done", 64'(busy), 64'd0);
    held = res;
    @(negedge clk);
    chk(done == 1'b0, "R6 pulse", 64'(done), 64'd0);
    chk(res == held, "R7 hold", res, held);
  endtask

  initial begin
    #(10 * 150000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb, rm, e1, e2;
    int e;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {62'd0, busy, done}, 64'd0);
    chk(res == '0, "R1 result in reset", res, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && res == '0, "R1 after release", res, 64'd0);

    for (int i = 0; i < NV; i++)
      run_one(VEC[i][0], VEC[i][1], VEC[i][2],
              (VEC[i][0] == '0 || VEC[i][1] == '0) ? "R8 zero operand" : "R3 table");

    for (int i = 0; i < 20; i++) begin
      rm = {$urandom, $urandom} | 64'd1;
      if (i % 2 == 0) rm[63] = 1'b1;
      rb = {$urandom, $urandom} % rm;
      ra = {$urandom, $urandom};
      run_one(ra, rb, rm, "R3 random");
    end

    // R3 modulus of one
    run_one(64'h1234_5678, 64'd0, 64'd1, "R3 unit modulus");

    // R5: start and new operands mid-run are ignored
    e1 = ref_mont(VEC[0][0], VEC[0][1], VEC[0][2]);
    kick(VEC[0][0], VEC[0][1], VEC[0][2]);
    repeat (5) @(negedge clk);
    a = 64'h5555; b = 64'h7; m = 64'hB; mp = inv_neg(64'hB);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(e);
    chk(res == e1, "R5 ignored start", res, e1);
    chk(e == N + 2 - 6, "R5 latency unchanged", 64'(e), 64'(N + 2 - 6));

    // R6: start in the done cycle is accepted
    e1 = ref_mont(VEC[5][0], VEC[5][1], VEC[5][2]);
    e2 = ref_mont(VEC[1][0], VEC[1][1], VEC[1][2]);
    @(negedge clk);
    kick(VEC[5][0], VEC[5][1], VEC[5][2]);
    wait_done(e);
    chk(res == e1, "R6 first result", res, e1);
    kick(VEC[1][0], VEC[1][1], VEC[1][2]);
    chk(busy == 1'b1, "R6 back-to-back accepted", 64'(busy), 64'd1);
    chk(res == e1, "R7 hold during run", res, e1);
    wait_done(e);
    chk(e == N + 2, "R6 second latency", 64'(e), 64'(N + 2));
    chk(res == e2, "R6 second result", res, e2);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule